// File: doc/BRIEF.md
# Self-Calibrating Pulse-Width Serial Receiver

This block decodes a single-wire serial line on which each bit cell opens with a high-to-low transition, and the bit value is carried by how long the line stays low before it returns high. Falling edges are spaced one bit period apart, while the rising edge moves within the cell. Each frame opens with a start bit whose low time sets the decision point between short (0) and long (1) pulses. Because of this, the receiver follows whatever rate the sender uses, frame by frame, with no configured bit rate.

The raw line is synchronized and edge-detected. A low-time counter runs from each falling edge to the next rising edge. A four-state controller stores the start-bit measurement as the threshold and classifies eight data bits against it. It then hands the byte out with a single-cycle strobe. A stall in any wait state longer than a parameterized number of clocks raises a one-cycle error, drops the partial byte and returns the receiver to idle.

Top module: `pulse_width_rx`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `rx_byte` is 0 and `rx_valid` and `rx_err` are 0. Reset also clears the stored threshold and returns the controller to idle.
- R2: The line idles high. In idle, only a falling edge starts a frame. A line held high for any length of time, or a rising edge seen in idle, produces neither `rx_valid` nor `rx_err`.
- R3: The low time of the start bit, counted in clocks from its falling edge to its rising edge, becomes the threshold for the rest of that frame.
- R4: A data bit whose low time, counted the same way, is strictly greater than the threshold decodes as 1.
- R5: A data bit whose low time is equal to or less than the threshold decodes as 0. A pulse exactly as long as the start bit gives 0, and one clock longer gives 1.
- R6: The first data bit received goes to `rx_byte[7]` and the eighth goes to `rx_byte[0]`.
- R7: After the rising edge of the eighth data bit, `rx_valid` is high for exactly one clock with the new byte on `rx_byte`. The receiver then waits for a new start bit, so frames can follow back to back.
- R8: The threshold is measured again in every frame, so consecutive frames at different bit rates each decode correctly.
- R9: The low-time counter is CNT_W bits wide (default 16) and stops at its all-ones value instead of wrapping.
- R10: If any non-idle wait state lasts TIMEOUT clocks without its expected edge, `rx_err` pulses for one clock, no byte is delivered, the partial byte is dropped and the receiver returns to idle. The next full frame decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Raw serial line, asynchronous to clk, idles high |
| rx_byte | output | 8 | Last completed byte, first bit received in bit 7 |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |
| rx_err | output | 1 | One-cycle strobe when a wait state times out |

## Verification
A wrong threshold or a wrong comparison shows up in `rx_byte` at the strobe that ends the frame in which it happens. The equal-length pulse case tells a strict comparison from an inclusive one. A controller that leaves idle on the wrong event, or never returns to it, shows up as missing, extra or wrong strobes within one frame, or as an `rx_err` pulse within TIMEOUT clocks. A counter that wraps instead of stopping only shows up when pulses are longer than its range, so a narrow-counter instance receives pulses that would alias to short counts if the counter wrapped.

// File: rtl/pulse_width_rx.sv
module pulse_width_rx #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_in,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err
);
  localparam int WW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {IDLE, START_LO, BIT_HI, BIT_LO} st_t;
  st_t st;

  logic [1:0]       sync;
  logic             prev;
  logic [CNT_W-1:0] lo_cnt, thr;
  logic [WW-1:0]    wait_cnt;
  logic [6:0]       shreg;
  logic [2:0]       nbits;

  wire fall   = prev & ~sync[1];
  wire rise   = ~prev & sync[1];
  wire in_lo  = (st == START_LO) || (st == BIT_LO);
  wire event_ = in_lo ? rise : fall;
  wire bit_v  = lo_cnt > thr;
  wire [CNT_W-1:0] lo_inc = (&lo_cnt) ? lo_cnt : lo_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      prev     <= 1'b1;
      st       <= IDLE;
      lo_cnt   <= '0;
      thr      <= '0;
      wait_cnt <= '0;
      shreg    <= '0;
      nbits    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      sync     <= {sync[0], line_in};
      prev     <= sync[1];
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (st != IDLE && !event_) begin
        if (in_lo) lo_cnt <= lo_inc;
        if (wait_cnt == WW'(TIMEOUT - 1)) begin
          rx_err   <= 1'b1;
          st       <= IDLE;
          shreg    <= '0;
          nbits    <= '0;
          wait_cnt <= '0;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end else if (event_) begin
        wait_cnt <= '0;
        case (st)
          IDLE: begin
            lo_cnt <= '0;
            st     <= START_LO;
          end
          START_LO: begin
            thr <= lo_cnt;
            st  <= BIT_HI;
          end
          BIT_HI: begin
            lo_cnt <= '0;
            st     <= BIT_LO;
          end
          BIT_LO: begin
            shreg <= {shreg[5:0], bit_v};
            nbits <= nbits + 1'b1;
            if (nbits == 3'd7) begin
              rx_byte  <= {shreg, bit_v};
              rx_valid <= 1'b1;
              st       <= IDLE;
            end else begin
              st <= BIT_HI;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_err)); // R10
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> (st == IDLE) && (nbits == 3'd0)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == IDLE) && !fall |=> (st == IDLE)); // R2
  AST_THR_FROM_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(thr) |-> $past(st) == START_LO); // R3
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    in_lo && (&lo_cnt) && !rise && !rx_err |=> (&lo_cnt)); // R9
  AST_VALID_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(st) == BIT_LO); // R7
endmodule

// File: tb/test_pulse_width_rx.sv
module test_pulse_width_rx;
  localparam int TO = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in = 1'b1;
  logic [7:0] rx_byte, sat_byte;
  logic       rx_valid, rx_err, sat_valid, sat_err;

  int total = 0, bad = 0;
  int vcnt = 0, ecnt = 0;
  logic [7:0] last_byte = '0, last_sat = '0;

  always #10 clk = ~clk;

  pulse_width_rx #(.CNT_W(16), .TIMEOUT(TO)) i_pulse_width_rx (
    .clk(clk), .rst(rst), .line_in(line_in),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err));

  pulse_width_rx #(.CNT_W(4), .TIMEOUT(TO)) i_pulse_width_rx_sat (
    .clk(clk), .rst(rst), .line_in(line_in),
    .rx_byte(sat_byte), .rx_valid(sat_valid), .rx_err(sat_err));

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin vcnt++; last_byte = rx_byte; end
      if (rx_err) ecnt++;
      if (sat_valid) last_sat = sat_byte;
    end
  end

  // {half-period low time, byte}
  localparam logic [15:0] VEC [6] = '{
    {8'd8,  8'hA5}, {8'd12, 8'h3C}, {8'd20, 8'hFF},
    {8'd30, 8'h00}, {8'd6,  8'h81}, {8'd40, 8'h5E}};

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(int lo, int per);
    line_in = 1'b0;
    repeat (lo) @(negedge clk);
    line_in = 1'b1;
    repeat (per - lo) @(negedge clk);
  endtask

  task automatic send_frame(int h, logic [7:0] b, int lo0, int lo1, int per);
    pulse(h, per);
    for (int i = 7; i >= 0; i--) pulse(b[i] ? lo1 : lo0, per);
  endtask

  task automatic send_std(int h, logic [7:0] b);
    send_frame(h, b, h / 2, h + h / 2, 2 * h + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, e0;
    repeat (2) @(negedge clk);
    check("R1 byte in reset", int'(rx_byte), 0);
    check("R1 valid in reset", int'(rx_valid), 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 byte after reset", int'(rx_byte), 0);
    check("R1 err after reset", int'(rx_err), 0);

    // R3 R4 R5 R6 R7 R8: table of frames at varying rates, back to back
    for (int i = 0; i < 6; i++) begin
      v0 = vcnt;
      send_std(int'(VEC[i][15:8]), VEC[i][7:0]);
      repeat (6) @(negedge clk);
      check("R7 one strobe per frame", vcnt - v0, 1);
      check("R8 R6 byte value", int'(last_byte), int'(VEC[i][7:0]));
    end
    check("R10 no spurious error", ecnt, 0);

    // R5 strict compare: equal low time -> 0, one clock longer -> 1
    v0 = vcnt;
    send_frame(10, 8'h53, 10, 11, 30);
    repeat (6) @(negedge clk);
    check("R5 equal-length strobe", vcnt - v0, 1);
    check("R5 R4 equal is 0, +1 is 1", int'(last_byte), 8'h53);

    // R9 saturation on narrow counter: 40-cycle pulses would wrap below threshold
    send_frame(10, 8'hFF, 5, 40, 60);
    repeat (6) @(negedge clk);
    check("R9 saturated count decodes 1", int'(last_sat), 8'hFF);
    check("R9 wide instance agrees", int'(last_byte), 8'hFF);

    // R2 long idle high: nothing happens
    v0 = vcnt; e0 = ecnt;
    repeat (TO + 100) @(negedge clk);
    check("R2 idle no strobe", vcnt - v0, 0);
    check("R2 idle no error", ecnt - e0, 0);

    // R10 stall mid-frame with line high
    v0 = vcnt; e0 = ecnt;
    pulse(10, 24);
    pulse(5, 24); pulse(15, 24); pulse(15, 24);
    repeat (TO + 20) @(negedge clk);
    check("R10 stall raises one error", ecnt - e0, 1);
    check("R10 stall no byte", vcnt - v0, 0);
    check("R10 byte unchanged", int'(rx_byte), 8'hFF);
    send_std(10, 8'h2D);
    repeat (6) @(negedge clk);
    check("R10 partial dropped, next frame ok", int'(last_byte), 8'h2D);

    // R10 stuck low in start bit, then R2 rising edge in idle ignored
    v0 = vcnt; e0 = ecnt;
    line_in = 1'b0;
    repeat (TO + 20) @(negedge clk);
    check("R10 stuck-low error", ecnt - e0, 1);
    line_in = 1'b1;
    repeat (TO + 20) @(negedge clk);
    check("R2 rise in idle ignored", ecnt - e0, 1);
    check("R2 rise in idle no byte", vcnt - v0, 0);
    send_std(16, 8'hC6);
    repeat (6) @(negedge clk);
    check("R3 recovery frame", int'(last_byte), 8'hC6);

    // R1 reset mid-frame returns to idle
    pulse(10, 24); pulse(15, 24);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 byte cleared by reset", int'(rx_byte), 0);
    v0 = vcnt; e0 = ecnt;
    send_std(9, 8'h96);
    repeat (6) @(negedge clk);
    check("R1 clean frame after reset", int'(last_byte), 8'h96);
    check("R1 no error after reset", ecnt - e0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule